// File: doc/BRIEF.md
# BAR Sizing and Base Assignment Engine

This block sits on the host side of a configuration path. It enumerates the base address registers of a single function and assigns an address to each. Each slot is probed in turn over a simple request/response channel. The engine writes all ones to the slot and reads the slot back. From the returned pattern it decodes whether the slot is unimplemented, memory or I/O, 32- or 64-bit, and prefetchable, and it derives the power-of-two size of the window.

A window that is present receives a base address taken from one of two running allocation pointers. Prefetchable memory draws on a 64-bit pointer. Non-prefetchable memory and I/O draw on a 32-bit pointer. The pointer is first rounded up to a multiple of the window size, and the chosen base is written back into the slot, or into both slots of a 64-bit pair.

When the last slot has been handled, a done flag rises. The per-slot results then stay on the outputs until software pulses start again.

Top module: `bar_alloc_engine`

## Requirements
- R1: For every slot index i that is probed, the engine first issues a write (write flag 1) of 0xFFFFFFFF to index i and then a read of index i, before it touches any other index.
- R2: A read-back of 0x00000000 marks the slot as unimplemented. Its valid output stays 0, no base write is issued to it, and probing moves on to the next index.
- R3: Read-back bit 0 set means I/O. With bit 0 clear, bits [2:1] = 2'b10 mean a 64-bit memory window, and bit 3 set means prefetchable. Bit 3 is ignored for I/O.
- R4: The size is the two's complement of the read-back after clearing its low 4 bits (memory) or its low 2 bits (I/O). The upper 32 bits are taken as all ones unless an upper slot was read.
- R5: For a 64-bit window at index i below the last index, the engine writes all ones to i+1, reads it back, and uses that value as the upper half of the mask. Index i+1 is then consumed: its valid stays 0 and it is not probed as a window of its own. A 64-bit window at the last index is sized from its lower slot only.
- R6: The assigned base is the selected pointer rounded up to the next multiple of the size. That pointer then becomes base plus size.
- R7: Prefetchable memory windows use a 64-bit pointer that starts at PF_INIT. All other windows use a 32-bit pointer that starts at NP_INIT. Both pointers reload on every start.
- R8: The engine writes the low 32 bits of the base to index i. For a 64-bit pair it also writes the high 32 bits to index i+1.
- R9: Request valid, write flag, index and write data hold steady from the cycle the request is raised until the cycle in which response valid is seen. Exactly one access completes per response.
- R10: Done rises after the last index has been handled. Done and all per-slot outputs then hold until the next start. A start received while a run is in progress is ignored.
- R11: After reset, done, request valid and every valid output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an enumeration pass (honoured when idle or done) |
| cfg_req_valid_o | output | 1 | Configuration access request |
| cfg_req_write_o | output | 1 | 1 = write, 0 = read |
| cfg_req_idx_o | output | 3 | Slot index of the access |
| cfg_req_wdata_o | output | 32 | Write data |
| cfg_rsp_valid_i | input | 1 | Access completed |
| cfg_rsp_rdata_i | input | 32 | Read data, sampled with response valid |
| done_o | output | 1 | Pass finished |
| bar_valid_o | output | 6 | Slot received an assignment |
| bar_io_o | output | 6 | Slot is I/O |
| bar_64_o | output | 6 | Slot is a 64-bit memory window |
| bar_pref_o | output | 6 | Slot is prefetchable memory |
| bar_size_o | output | 384 | Per-slot size, 64 bits per slot, slot 0 in the low bits |
| bar_base_o | output | 384 | Per-slot assigned base, 64 bits per slot |

## Verification
The bench sweeps two dozen slot layouts against a behavioural device model, and the response latency varies from access to access. Each layout mixes unimplemented slots, I/O, 32-bit memory and 64-bit pairs, and some pairs need more than 4 GB. A pair decoded without its upper slot would report a huge bogus size. An engine that advanced by one slot after a pair would probe the upper half as a window of its own. A missed alignment shows up as a base that is not a multiple of the size, because both start pointers are deliberately misaligned. A 64-bit window in the last slot checks that the engine does not read past the end. A second start pulse in mid-run must not add any accesses.

// File: rtl/bar_alloc_pkg.sv
package bar_alloc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ONES_LO, ST_READ_LO, ST_ONES_HI, ST_READ_HI,
    ST_BASE_LO, ST_BASE_HI, ST_STEP, ST_DONE
  } eng_state_e;

  localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;

  // memory window whose type field marks a 64-bit decoder
  function automatic logic is_mem64(input logic [31:0] rb);
    return !rb[0] && (rb[2:1] == 2'b10);
  endfunction

  // two's complement of an address mask gives the window size
  function automatic logic [63:0] size_of_mask(input logic [63:0] m);
    return ~m + 64'd1;
  endfunction

  // round a pointer up to a multiple of a power-of-two size
  function automatic logic [63:0] round_up(input logic [63:0] p, input logic [63:0] s);
    return (p + s - 64'd1) & ~(s - 64'd1);
  endfunction

endpackage

// File: rtl/bar_attr_decode.sv
module bar_attr_decode
  import bar_alloc_pkg::*;
(
  input  logic [31:0] lo_rb_i,
  input  logic [31:0] hi_rb_i,
  input  logic        hi_present_i,
  output logic        empty_o,
  output logic        io_o,
  output logic        w64_o,
  output logic        pref_o,
  output logic [63:0] size_o
);
  logic [31:0] lo_clr;
  logic [31:0] hi_mask;

  always_comb begin
    io_o    = lo_rb_i[0];
    w64_o   = is_mem64(lo_rb_i);
    pref_o  = !lo_rb_i[0] && lo_rb_i[3];
    empty_o = (lo_rb_i == 32'd0);
    lo_clr  = lo_rb_i[0] ? (lo_rb_i & 32'hFFFF_FFFC) : (lo_rb_i & 32'hFFFF_FFF0);
    hi_mask = (w64_o && hi_present_i) ? hi_rb_i : ALL_ONES;
    size_o  = size_of_mask({hi_mask, lo_clr});
  end
endmodule

// File: rtl/bar_space_ptr.sv
module bar_space_ptr
  import bar_alloc_pkg::*;
#(
  parameter int PW = 32,
  parameter logic [PW-1:0] INIT = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic        take_i,
  input  logic [63:0] size_i,
  output logic [63:0] base_o
);
  logic [PW-1:0] ptr_q;
  logic [63:0]   ptr_ext;

  assign ptr_ext = 64'(ptr_q);
  assign base_o  = round_up(ptr_ext, size_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= INIT;
    else if (load_i) ptr_q <= INIT;
    else if (take_i) ptr_q <= PW'(base_o + size_i);
  end

  // R6
  base_not_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> (base_o >= ptr_ext));

  // R6
  ptr_moves_past_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && !load_i |=> (ptr_ext == 64'(PW'($past(base_o) + $past(size_i)))));
endmodule

// File: rtl/bar_alloc_engine.sv
module bar_alloc_engine
  import bar_alloc_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter logic [31:0] NP_INIT = 32'h4000_0010,
  parameter logic [63:0] PF_INIT = 64'h0000_0004_0000_0800,
  localparam int IW = $clog2(NUM_BARS),
  localparam int CW = $clog2(NUM_BARS + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  output logic                   cfg_req_valid_o,
  output logic                   cfg_req_write_o,
  output logic [IW-1:0]          cfg_req_idx_o,
  output logic [31:0]            cfg_req_wdata_o,
  input  logic                   cfg_rsp_valid_i,
  input  logic [31:0]            cfg_rsp_rdata_i,
  output logic                   done_o,
  output logic [NUM_BARS-1:0]    bar_valid_o,
  output logic [NUM_BARS-1:0]    bar_io_o,
  output logic [NUM_BARS-1:0]    bar_64_o,
  output logic [NUM_BARS-1:0]    bar_pref_o,
  output logic [NUM_BARS*64-1:0] bar_size_o,
  output logic [NUM_BARS*64-1:0] bar_base_o
);
  eng_state_e  state_q;
  logic [CW-1:0] idx_q;
  logic [31:0] lo_rb_q, hi_rb_q;
  logic        hi_taken_q;
  logic [63:0] base_q;

  logic [NUM_BARS-1:0] res_valid_q, res_io_q, res_64_q, res_pref_q;
  logic [63:0] res_size_q [NUM_BARS];
  logic [63:0] res_base_q [NUM_BARS];

  // named events for the assertions
  logic idle_like, start_ev, commit_ev;
  logic dec_empty, dec_io, dec_w64, dec_pref;
  logic [63:0] dec_size, np_base, pf_base, cur_base;
  logic [CW-1:0] nxt_idx;
  logic [IW-1:0] hi_idx;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign start_ev  = idle_like && start_i;
  assign commit_ev = (state_q == ST_BASE_LO) && cfg_rsp_valid_i;
  assign nxt_idx   = idx_q + (hi_taken_q ? CW'(2) : CW'(1));
  assign hi_idx    = IW'(idx_q + CW'(1));
  assign done_o    = (state_q == ST_DONE);

  bar_attr_decode u_dec (
    .lo_rb_i(lo_rb_q), .hi_rb_i(hi_rb_q), .hi_present_i(hi_taken_q),
    .empty_o(dec_empty), .io_o(dec_io), .w64_o(dec_w64), .pref_o(dec_pref),
    .size_o(dec_size)
  );

  bar_space_ptr #(.PW(32), .INIT(NP_INIT)) u_np_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(start_ev),
    .take_i(commit_ev && !dec_pref), .size_i(dec_size), .base_o(np_base)
  );

  bar_space_ptr #(.PW(64), .INIT(PF_INIT)) u_pf_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(start_ev),
    .take_i(commit_ev && dec_pref), .size_i(dec_size), .base_o(pf_base)
  );

  assign cur_base = dec_pref ? pf_base : np_base;

  always_comb begin
    cfg_req_valid_o = 1'b0;
    cfg_req_write_o = 1'b0;
    cfg_req_idx_o   = idx_q[IW-1:0];
    cfg_req_wdata_o = ALL_ONES;
    case (state_q)
      ST_ONES_LO: begin cfg_req_valid_o = 1'b1; cfg_req_write_o = 1'b1; end
      ST_READ_LO: cfg_req_valid_o = 1'b1;
      ST_ONES_HI: begin cfg_req_valid_o = 1'b1; cfg_req_write_o = 1'b1; cfg_req_idx_o = hi_idx; end
      ST_READ_HI: begin cfg_req_valid_o = 1'b1; cfg_req_idx_o = hi_idx; end
      ST_BASE_LO: begin
        cfg_req_valid_o = 1'b1; cfg_req_write_o = 1'b1; cfg_req_wdata_o = cur_base[31:0];
      end
      ST_BASE_HI: begin
        cfg_req_valid_o = 1'b1; cfg_req_write_o = 1'b1; cfg_req_idx_o = hi_idx;
        cfg_req_wdata_o = base_q[63:32];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      lo_rb_q     <= '0;
      hi_rb_q     <= ALL_ONES;
      hi_taken_q  <= 1'b0;
      base_q      <= '0;
      res_valid_q <= '0;
      res_io_q    <= '0;
      res_64_q    <= '0;
      res_pref_q  <= '0;
      for (int k = 0; k < NUM_BARS; k++) begin
        res_size_q[k] <= '0;
        res_base_q[k] <= '0;
      end
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          idx_q       <= '0;
          res_valid_q <= '0;
          res_io_q    <= '0;
          res_64_q    <= '0;
          res_pref_q  <= '0;
          for (int k = 0; k < NUM_BARS; k++) begin
            res_size_q[k] <= '0;
            res_base_q[k] <= '0;
          end
          state_q <= ST_ONES_LO;
        end
        ST_ONES_LO: if (cfg_rsp_valid_i) state_q <= ST_READ_LO;
        ST_READ_LO: if (cfg_rsp_valid_i) begin
          lo_rb_q    <= cfg_rsp_rdata_i;
          hi_rb_q    <= ALL_ONES;
          hi_taken_q <= 1'b0;
          if (cfg_rsp_rdata_i == 32'd0) state_q <= ST_STEP;
          else if (is_mem64(cfg_rsp_rdata_i) && (idx_q < CW'(NUM_BARS - 1))) state_q <= ST_ONES_HI;
          else state_q <= ST_BASE_LO;
        end
        ST_ONES_HI: if (cfg_rsp_valid_i) state_q <= ST_READ_HI;
        ST_READ_HI: if (cfg_rsp_valid_i) begin
          hi_rb_q    <= cfg_rsp_rdata_i;
          hi_taken_q <= 1'b1;
          state_q    <= ST_BASE_LO;
        end
        ST_BASE_LO: if (cfg_rsp_valid_i) begin
          res_valid_q[idx_q[IW-1:0]] <= 1'b1;
          res_io_q[idx_q[IW-1:0]]    <= dec_io;
          res_64_q[idx_q[IW-1:0]]    <= dec_w64;
          res_pref_q[idx_q[IW-1:0]]  <= dec_pref;
          res_size_q[idx_q[IW-1:0]]  <= dec_size;
          res_base_q[idx_q[IW-1:0]]  <= cur_base;
          base_q  <= cur_base;
          state_q <= hi_taken_q ? ST_BASE_HI : ST_STEP;
        end
        ST_BASE_HI: if (cfg_rsp_valid_i) state_q <= ST_STEP;
        ST_STEP: begin
          idx_q   <= nxt_idx;
          state_q <= (nxt_idx >= CW'(NUM_BARS)) ? ST_DONE : ST_ONES_LO;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_out
    assign bar_size_o[g*64 +: 64] = res_size_q[g];
    assign bar_base_o[g*64 +: 64] = res_base_q[g];
  end
  assign bar_valid_o = res_valid_q;
  assign bar_io_o    = res_io_q;
  assign bar_64_o    = res_64_q;
  assign bar_pref_o  = res_pref_q;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid_o && !cfg_rsp_valid_i |=> cfg_req_valid_o && $stable(cfg_req_idx_o)
      && $stable(cfg_req_write_o) && $stable(cfg_req_wdata_o));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cfg_req_valid_o);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable(bar_valid_o) && $stable(bar_base_o)
      && $stable(bar_size_o));

  // R2
  no_empty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |-> !dec_empty);

  // R4
  size_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |-> ($countones(dec_size) == 1));

  // R5
  pair_upper_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev && hi_taken_q |=> cfg_req_valid_o && cfg_req_write_o && (cfg_req_idx_o == hi_idx));
endmodule

// File: tb/bar_alloc_engine_test.sv
module bar_alloc_engine_test;
  localparam int N = 6;
  localparam logic [31:0] NP0 = 32'h4000_0010;
  localparam logic [63:0] PF0 = 64'h0000_0004_0000_0800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic req_v, req_w, rsp_v, done;
  logic [2:0] req_i;
  logic [31:0] req_d, rsp_d;
  logic [N-1:0] v_o, io_o, w64_o, pf_o;
  logic [N*64-1:0] sz_o, bs_o;

  always #2.5 clk = ~clk;

  bar_alloc_engine uut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .cfg_req_valid_o(req_v), .cfg_req_write_o(req_w), .cfg_req_idx_o(req_i),
    .cfg_req_wdata_o(req_d), .cfg_rsp_valid_i(rsp_v), .cfg_rsp_rdata_i(rsp_d),
    .done_o(done), .bar_valid_o(v_o), .bar_io_o(io_o), .bar_64_o(w64_o),
    .bar_pref_o(pf_o), .bar_size_o(sz_o), .bar_base_o(bs_o)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // device model: kind 0 none, 1 mem32, 2 mem64, 3 io, 4 upper half of a pair
  int kind [N];
  bit pr [N];
  int szl [N];
  logic [31:0] regs [N];
  bit ones_seen [N];
  int acc_cnt = 0, order_err = 0, hold_err = 0;

  function automatic logic [31:0] attr(int j);
    if (kind[j] == 3) return 32'h1;
    if (kind[j] == 2) return 32'h4 | (pr[j] ? 32'h8 : 32'h0);
    if (kind[j] == 1) return pr[j] ? 32'h8 : 32'h0;
    return 32'h0;
  endfunction

  function automatic logic [31:0] lmask(int j);
    logic [63:0] m;
    m = ~((64'd1 << szl[j]) - 64'd1);
    return m[31:0] & ((kind[j] == 3) ? 32'hFFFF_FFFC : 32'hFFFF_FFF0);
  endfunction

  function automatic logic [31:0] hmask(int j);
    logic [63:0] m;
    m = ~((64'd1 << szl[j]) - 64'd1);
    return m[63:32];
  endfunction

  // responder with varying latency; checks request hold while waiting
  bit pend = 0;
  int wcnt = 0;
  logic lw; logic [2:0] li; logic [31:0] ld;
  initial begin rsp_v = 1'b0; rsp_d = '0; end
  always @(posedge clk) begin
    if (rsp_v) rsp_v <= 1'b0;
    else if (pend) begin
      if (!req_v || req_w != lw || req_i != li || req_d != ld) hold_err++;
      if (wcnt == 0) begin
        pend = 0;
        acc_cnt++;
        if (lw) begin
          if (li < N) begin
            if (kind[li] == 4) regs[li] = ld & hmask(li - 1);
            else if (kind[li] != 0) regs[li] = (ld & lmask(li)) | attr(li);
            ones_seen[li] = (ld == 32'hFFFF_FFFF);
          end
          rsp_d <= '0;
        end else begin
          if (li < N) begin
            if (!ones_seen[li]) order_err++;
            ones_seen[li] = 0;
            rsp_d <= regs[li];
          end else rsp_d <= '0;
        end
        rsp_v <= 1'b1;
      end else wcnt--;
    end else if (req_v) begin
      lw = req_w; li = req_i; ld = req_d;
      pend = 1;
      wcnt = acc_cnt % 3;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic build(input int t);
    int i, k;
    for (int j = 0; j < N; j++) begin kind[j] = 0; pr[j] = 0; szl[j] = 4; ones_seen[j] = 0; end
    i = 0;
    while (i < N) begin
      k = (t == 0) ? 0 : (t * 3 + i * 5 + t / 4) % 4;
      kind[i] = k;
      if (k == 3) szl[i] = 2 + (t + i) % 7;
      else if (k != 0) begin
        pr[i] = ((t + i) % 2) == 1;
        szl[i] = 4 + (t * 5 + i * 3) % 17;
        if (k == 2 && pr[i] && i < N - 1) szl[i] = 4 + (t * 5 + i * 3) % 30;
      end
      if (k == 2 && i < N - 1) begin
        kind[i + 1] = 4; szl[i + 1] = szl[i]; i += 2;
      end else i += 1;
    end
    for (int j = 0; j < N; j++) regs[j] = (kind[j] == 0 || kind[j] == 4) ? 32'h0 : attr(j);
  endtask

  task automatic run(input int t, input bit extra_start);
    logic [63:0] np, pf, sz, p, bs;
    logic [63:0] eb [N];
    bit ev [N];
    int exp_acc, a0, o0, h0;
    logic [N-1:0] sv;
    logic [N*64-1:0] ss, sb;
    build(t);
    np = 64'(NP0); pf = PF0; exp_acc = 0;
    for (int j = 0; j < N; j++) begin
      ev[j] = 0; eb[j] = 0;
      if (kind[j] == 0) exp_acc += 2;
      else if (kind[j] != 4) begin
        exp_acc += (kind[j] == 2 && j < N - 1) ? 6 : 3;
        sz = 64'd1 << szl[j];
        p = pr[j] ? pf : np;
        bs = ((p + sz - 64'd1) / sz) * sz;
        if (pr[j]) pf = bs + sz; else np = (bs + sz) & 64'hFFFF_FFFF;
        ev[j] = 1; eb[j] = bs;
      end
    end
    a0 = acc_cnt; o0 = order_err; h0 = hold_err;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    if (extra_start) begin
      repeat (7) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(done === 1'b1, "R10 done", done, 1);
    chk(acc_cnt - a0 == exp_acc, "R1/R5 access count", acc_cnt - a0, exp_acc);
    chk(order_err == o0, "R1 ones-before-read order", order_err - o0, 0);
    chk(hold_err == h0, "R9 request hold", hold_err - h0, 0);
    for (int j = 0; j < N; j++) begin
      chk(v_o[j] == ev[j], (kind[j] == 4) ? "R5 upper slot consumed" : "R2 valid", v_o[j], ev[j]);
      if (ev[j]) begin
        chk(io_o[j] == (kind[j] == 3), "R3 io", io_o[j], kind[j] == 3);
        chk(w64_o[j] == (kind[j] == 2), "R3 64-bit", w64_o[j], kind[j] == 2);
        chk(pf_o[j] == pr[j], "R3 prefetch", pf_o[j], pr[j]);
        chk(sz_o[j*64 +: 64] == (64'd1 << szl[j]), "R4 size", sz_o[j*64 +: 64], 64'd1 << szl[j]);
        chk(bs_o[j*64 +: 64] == eb[j], "R6/R7 base", bs_o[j*64 +: 64], eb[j]);
        chk(regs[j] == ((eb[j][31:0] & lmask(j)) | attr(j)), "R8 low write", regs[j],
            (eb[j][31:0] & lmask(j)) | attr(j));
        if (kind[j] == 2 && j < N - 1)
          chk(regs[j + 1] == (eb[j][63:32] & hmask(j)), "R8 high write", regs[j + 1],
              eb[j][63:32] & hmask(j));
      end else if (kind[j] == 0) begin
        chk(regs[j] == 32'h0, "R2 no write", regs[j], 0);
      end
    end
    sv = v_o; ss = sz_o; sb = bs_o;
    repeat (10) @(negedge clk);
    chk(done && v_o == sv && sz_o == ss && bs_o == sb, "R10 results held", {63'd0, done}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < N; j++) begin kind[j] = 0; regs[j] = 0; ones_seen[j] = 0; pr[j] = 0; szl[j] = 4; end
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R11 done after reset", done, 0);
    chk(req_v == 1'b0, "R11 request after reset", req_v, 0);
    chk(v_o == '0, "R11 valid after reset", v_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int t = 0; t < 24; t++) run(t, 1'b0);
    run(5, 1'b1);
    run(13, 1'b1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule